// File: doc/BRIEF.md
# Next-Address Instruction Fetch Unit

This block owns the program counter of a single-cycle processor and works out, every clock, where the next instruction will be fetched from. The counter is held as a word address, so its two lowest byte-address bits are always zero and are never stored. Incrementing is done by an adder whose carry-in is tied high. The same style of adder, with the sign-extended branch offset as its second operand, produces the branch target. The offset is counted in words, so no shift is needed.

Each cycle the unit receives the offset and jump-target fields of the current instruction, the zero flag from the ALU, and the branch and jump control bits. It then picks one of three candidates. The sequential address is the default. The branch target is taken only when branch and zero are both high. The jump address keeps the top bits of the incremented counter and replaces the rest with the target field. Jump wins if both controls are high. An enable input freezes the counter. The unit drives the byte address to the instruction memory and the byte address of the following word.

Top module: `instr_fetch_unit`

## Requirements
- R1: While `rst_n` is low the counter is word address 0, so `fetch_addr` reads 0 and `pc_plus4` reads 4.
- R2: `fetch_addr` is the stored word address followed by two zero bits; its bits [1:0] are always 0.
- R3: `pc_plus4` always equals `fetch_addr` + 4, modulo 2^(PC_W+2).
- R4: With `en` high, `jump` low and `branch` low, the next `fetch_addr` is the current `pc_plus4`.
- R5: With `en` high, `jump` low, and `branch` and `zero` both high, the next `fetch_addr` is the current `pc_plus4` plus 4 times the two's-complement value of `imm`.
- R6: When exactly one of `branch` and `zero` is high (and `jump` low, `en` high), the counter advances sequentially, never to the branch target.
- R7: With `en` high and `jump` high, the next `fetch_addr` has `target` in bits [TGT_W+1:2], the top PC_W-TGT_W bits of the current `pc_plus4` above it, and 00 below.
- R8: When `jump`, `branch` and `zero` are all high, the jump address is taken.
- R9: With `en` low, `fetch_addr` holds its value whatever the other inputs do.
- R10: Sequential, branch and jump arithmetic wrap modulo the address space (word address 2^PC_W-1 is followed by 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance enable; low holds the counter |
| imm | input | IMM_W | Signed branch offset in words |
| target | input | TGT_W | Jump target field in words |
| zero | input | 1 | ALU zero flag |
| branch | input | 1 | Branch control bit |
| jump | input | 1 | Jump control bit |
| fetch_addr | output | PC_W+2 | Byte address to instruction memory |
| pc_plus4 | output | PC_W+2 | Byte address of the next sequential word |

## Verification
The bench builds the unit with PC_W=8, IMM_W=4 and TGT_W=5, so the counter space has only 256 words. Every offset value is applied with every combination of the three control bits and every jump target, and the counter wanders across the whole space. Negative offsets, wrap at both ends and the jump upper-bit splice are therefore all reached with few cycles, and each result is predicted with plain modular arithmetic.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
   typedef enum logic [1:0] {
      NXT_SEQ    = 2'd0,
      NXT_BRANCH = 2'd1,
      NXT_JUMP   = 2'd2
   } nxt_sel_e;
endpackage

// File: rtl/fetch_sext.sv
module fetch_sext #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 30
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   if (IN_W > OUT_W) begin : g_bad_w
      $error("fetch_sext: IN_W must not exceed OUT_W");
   end

   if (IN_W == OUT_W) begin : g_pass
      assign dout = din;
   end else begin : g_ext
      localparam int FILL_W = OUT_W - IN_W;
      assign dout = {{FILL_W{din[IN_W-1]}}, din};
   end
endmodule

// File: rtl/fetch_adder.sv
module fetch_adder #(
   parameter int W = 30
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum
);
   if (W < 2) begin : g_bad_w
      $error("fetch_adder: W must be at least 2");
   end

   assign sum = a + b + {{(W-1){1'b0}}, cin};
endmodule

// File: rtl/fetch_sel.sv
module fetch_sel
   import fetch_pkg::*;
(
   input  logic     branch,
   input  logic     zero,
   input  logic     jump,
   output nxt_sel_e sel
);
   always_comb begin
      if (jump)                sel = NXT_JUMP;
      else if (branch && zero) sel = NXT_BRANCH;
      else                     sel = NXT_SEQ;
   end
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
   parameter int W = 30
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] nxt,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
   end
endmodule

// File: rtl/instr_fetch_unit.sv
module instr_fetch_unit
   import fetch_pkg::*;
#(
   parameter int PC_W  = 30,
   parameter int IMM_W = 16,
   parameter int TGT_W = 26
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [IMM_W-1:0]    imm,
   input  logic [TGT_W-1:0]    target,
   input  logic                zero,
   input  logic                branch,
   input  logic                jump,
   output logic [PC_W+1:0]     fetch_addr,
   output logic [PC_W+1:0]     pc_plus4
);
   localparam int HI_W = PC_W - TGT_W;

   if (TGT_W >= PC_W) begin : g_bad_tgt
      $error("instr_fetch_unit: TGT_W must be below PC_W");
   end
   if (IMM_W > PC_W) begin : g_bad_imm
      $error("instr_fetch_unit: IMM_W must not exceed PC_W");
   end

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_inc;
   logic [PC_W-1:0] pc_br;
   logic [PC_W-1:0] pc_jmp;
   logic [PC_W-1:0] imm_ext;
   logic [PC_W-1:0] pc_nxt;
   nxt_sel_e        sel;

   fetch_sext #(.IN_W(IMM_W), .OUT_W(PC_W)) sext_i (
      .din  (imm),
      .dout (imm_ext)
   );

   fetch_adder #(.W(PC_W)) inc_add_i (
      .a   (pc_q),
      .b   ({PC_W{1'b0}}),
      .cin (1'b1),
      .sum (pc_inc)
   );

   fetch_adder #(.W(PC_W)) br_add_i (
      .a   (pc_q),
      .b   (imm_ext),
      .cin (1'b1),
      .sum (pc_br)
   );

   assign pc_jmp = {pc_inc[PC_W-1 -: HI_W], target};

   fetch_sel sel_i (
      .branch (branch),
      .zero   (zero),
      .jump   (jump),
      .sel    (sel)
   );

   always_comb begin
      unique case (sel)
         NXT_JUMP:   pc_nxt = pc_jmp;
         NXT_BRANCH: pc_nxt = pc_br;
         default:    pc_nxt = pc_inc;
      endcase
   end

   fetch_pc_reg #(.W(PC_W)) pc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .nxt   (pc_nxt),
      .q     (pc_q)
   );

   assign fetch_addr = {pc_q, 2'b00};
   assign pc_plus4   = {pc_inc, 2'b00};
endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
   parameter int PC_W  = 30,
   parameter int IMM_W = 16,
   parameter int TGT_W = 26
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [IMM_W-1:0] imm,
   input logic [TGT_W-1:0] target,
   input logic             zero,
   input logic             branch,
   input logic             jump,
   input logic [PC_W+1:0]  fetch_addr,
   input logic [PC_W+1:0]  pc_plus4
);
   localparam int AW   = PC_W + 2;
   localparam int HI_W = PC_W - TGT_W;

   logic [AW-1:0] off_b;
   assign off_b = AW'($signed(imm)) << 2;

   assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_addr[1:0] == 2'b00);

   assert_plus4_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pc_plus4 == fetch_addr + AW'(4));

   assert_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !jump && !branch) |=> fetch_addr == $past(pc_plus4));

   assert_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !jump && branch && zero) |=> fetch_addr == $past(pc_plus4) + $past(off_b));

   assert_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !jump && (branch != zero)) |=> fetch_addr == $past(pc_plus4));

   assert_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && jump) |=> fetch_addr == {$past(pc_plus4[AW-1 -: HI_W]), $past(target), 2'b00});

   assert_jump_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && jump && branch && zero) |=> fetch_addr[TGT_W+1:2] == $past(target));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(fetch_addr));
endmodule

bind instr_fetch_unit fetch_unit_chk #(
   .PC_W(PC_W), .IMM_W(IMM_W), .TGT_W(TGT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .imm        (imm),
   .target     (target),
   .zero       (zero),
   .branch     (branch),
   .jump       (jump),
   .fetch_addr (fetch_addr),
   .pc_plus4   (pc_plus4)
);

// File: tb/instr_fetch_unit_tb.sv
`timescale 1ns/1ps
module instr_fetch_unit_tb_top;
   localparam int PC_W  = 8;
   localparam int IMM_W = 4;
   localparam int TGT_W = 5;
   localparam int AW    = PC_W + 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [IMM_W-1:0] imm = '0;
   logic [TGT_W-1:0] target = '0;
   logic             zero = 1'b0;
   logic             branch = 1'b0;
   logic             jump = 1'b0;
   logic [AW-1:0]    fetch_addr;
   logic [AW-1:0]    pc_plus4;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [PC_W-1:0] m_pc = '0;

   always #4 clk = ~clk;

   instr_fetch_unit #(.PC_W(PC_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .imm(imm), .target(target),
      .zero(zero), .branch(branch), .jump(jump),
      .fetch_addr(fetch_addr), .pc_plus4(pc_plus4)
   );

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_state(input string req);
      logic [PC_W-1:0] inc;
      inc = m_pc + 1'b1;
      check(req, fetch_addr, {m_pc, 2'b00});
      check(req, pc_plus4, {inc, 2'b00});
   endtask

   function automatic logic [PC_W-1:0] model_next(
      input logic [PC_W-1:0] pc, input logic [IMM_W-1:0] im,
      input logic [TGT_W-1:0] tg, input logic b, input logic z, input logic j);
      logic [PC_W-1:0] inc;
      logic [PC_W-1:0] ofs;
      inc = pc + 1'b1;
      ofs = PC_W'($signed(im));
      if (j)          return {inc[PC_W-1:TGT_W], tg};
      else if (b && z) return inc + ofs;
      else            return inc;
   endfunction

   task automatic step(input logic e, input logic [IMM_W-1:0] im,
                       input logic [TGT_W-1:0] tg, input logic b,
                       input logic z, input logic j, input string req);
      en = e; imm = im; target = tg; branch = b; zero = z; jump = j;
      if (e) m_pc = model_next(m_pc, im, tg, b, z, j);
      @(negedge clk);
      check_state(req);
   endtask

   task automatic finish_report();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_report();
   end

   initial begin
      string tag;
      repeat (3) @(negedge clk);
      // R1 reset value, R2 low bits, R3 next word
      m_pc = '0;
      check("R1", fetch_addr, '0);
      check("R3", pc_plus4, AW'(4));
      check("R2", {8'd0, fetch_addr[1:0]}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1");

      // near-exhaustive sweep: every offset, every control combo, every target
      for (int t = 0; t < 32; t++) begin
         for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < 16; i++) begin
               logic b, z, j;
               b = c[0]; z = c[1]; j = c[2];
               if (j && b && z)  tag = "R8";
               else if (j)       tag = "R7";
               else if (b && z)  tag = "R5";
               else if (b || z)  tag = "R6";
               else              tag = "R4";
               step(1'b1, IMM_W'(i), TGT_W'(t), b, z, j, tag);
            end
         end
      end

      // R9: enable low holds against every control pattern
      for (int c = 0; c < 8; c++) begin
         step(1'b0, IMM_W'(c * 3), TGT_W'(c * 5), c[0], c[1], c[2], "R9");
      end

      // R10: wrap at the top and bottom of the space
      rst_n = 1'b0;
      m_pc = '0;
      @(negedge clk);
      check_state("R1");
      rst_n = 1'b1;
      step(1'b1, 4'hE, '0, 1'b1, 1'b1, 1'b0, "R10");   // 0 + 1 - 2 -> FF
      check("R10", fetch_addr, 10'h3FC);
      check("R10", pc_plus4, '0);
      step(1'b1, '0, '0, 1'b0, 1'b0, 1'b0, "R10");     // FF -> 00
      check("R10", fetch_addr, '0);
      step(1'b1, 4'h8, '0, 1'b1, 1'b1, 1'b0, "R10");   // 0 + 1 - 8 -> F9
      check("R5", fetch_addr, {8'hF9, 2'b00});
      step(1'b1, 4'h7, '0, 1'b1, 1'b1, 1'b0, "R10");   // F9 + 1 + 7 -> 01
      check("R10", fetch_addr, {8'h01, 2'b00});
      step(1'b1, 4'hE, '0, 1'b1, 1'b1, 1'b0, "R10");   // 01 + 1 - 2 -> 00
      step(1'b1, 4'hE, '0, 1'b1, 1'b1, 1'b0, "R10");   // -> FF
      step(1'b1, '0, 5'h1F, 1'b0, 1'b0, 1'b1, "R10");  // jump at FF: upper from 00
      check("R7", fetch_addr, {8'h1F, 2'b00});
      check("R2", {8'd0, fetch_addr[1:0]}, '0);

      finish_report();
   end
endmodule